// File: doc/BRIEF.md
# Split/Shared Peripheral Bus Datapath

This block sits between a chip's internal transmit and receive word streams and a 64-bit peripheral data bus whose pins can be used in two ways. In shared mode, every pin of the 64-bit data bus and all eight active-low byte-enable lanes carry one transfer at a time, in either direction. In split mode, the upper 32 bits form a transmit half that is always driven by this block, and the lower 32 bits form a receive half. The receive half is an input during receive cycles. It is driven by this block while a device-reset request is present or after the bus has been quiet for a set number of clocks. The mode is a static setting. It is chosen before traffic starts and is never changed while traffic is running.

All pad-side outputs are registered. A word accepted on the transmit stream appears on the pins in the next cycle. A receive cycle flagged by `rx_cyc` is sampled at the clock edge and shows up on the receive stream in the next cycle. The transmit stream follows valid/ready rules: a word moves when `tx_valid` and `tx_ready` are both high at a clock edge, and `tx_ready` never depends on `tx_valid`. In shared mode, `tx_ready` drops whenever `rx_cyc` is high, because a receive owns the bus for that cycle. In split mode, `tx_ready` stays high out of reset. The receive stream has no back-pressure, because the bus cannot be stalled. `rx_valid` is a one-cycle pulse that the consumer must take. A second static flag selects timing for one to two slaves or for three to seven slaves. This block only registers that flag and presents it to the bus timing logic.

Top module: `split_bus_datapath`

## Requirements
- R1: While `rst_n` is low, `hi_oe`, `lo_oe`, `rx_valid`, `tx_ready` and `idle_timeout` are 0, and `bus_be_n_out` is all ones.
- R2: In shared mode (`cfg_split`=0), a word accepted at an edge appears in the next cycle on `bus_dout` (all 64 bits), with `bus_be_n_out[k]` = NOT `tx_keep[k]` for every lane k, and with both `hi_oe` and `lo_oe` high. In a cycle that follows an edge with no accepted word, both enables are low and `bus_be_n_out` is all ones.
- R3: In shared mode, `tx_ready` is low in any cycle where `rx_cyc` is high, and high otherwise (out of reset).
- R4: In shared mode, `rx_cyc` high at an edge gives, in the next cycle, `rx_valid`=1, `rx_data`=`bus_din`, and `rx_keep[k]` = NOT `bus_be_n_in[k]` for all eight lanes. `rx_valid` is 0 after any edge where `rx_cyc` is low.
- R5: In split mode, `tx_ready` is high out of reset. An accepted word puts `tx_data[31:0]` on `bus_dout[63:32]` and NOT `tx_keep[3:0]` on `bus_be_n_out[7:4]` in the next cycle. `tx_data[63:32]` and `tx_keep[7:4]` are ignored.
- R6: In split mode, `hi_oe` is high in every cycle after the first edge out of reset. After an edge with no accepted word, `bus_be_n_out[7:4]` is 4'hF and `bus_dout[63:32]` keeps its last word.
- R7: In split mode, `rx_cyc` high at an edge gives, in the next cycle, `rx_valid`=1, `rx_data[31:0]`=`bus_din[31:0]` and `rx_keep[3:0]` = NOT `bus_be_n_in[3:0]`. `rx_data[63:32]` and `rx_keep[7:4]` are zero. `bus_din[63:32]` and `bus_be_n_in[7:4]` are ignored.
- R8: In split mode, `lo_oe` is high in the cycle after an edge where `rx_cyc` is low and either `dev_reset_req` or `idle_timeout` is high. Otherwise `lo_oe` is low. `bus_dout[31:0]` is always zero and `bus_be_n_out[3:0]` is always 4'hF in this mode.
- R9: In split mode, `idle_timeout` rises once IDLE_LIMIT consecutive edges have passed with `rx_cyc` low. It stays high until an edge with `rx_cyc` high, after which it is low.
- R10: In shared mode, `idle_timeout` stays low and `dev_reset_req` has no effect on any output.
- R11: `slave_sel` shows the value of `cfg_many_slaves` (1 = three to seven slaves) taken at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | Static mode: 0 shared 64-bit, 1 split halves |
| cfg_many_slaves | input | 1 | Static timing sub-mode: 0 one or two slaves, 1 three to seven |
| slave_sel | output | 1 | Registered sub-mode flag |
| dev_reset_req | input | 1 | Request to drive the receive half during device reset |
| idle_timeout | output | 1 | Split-mode quiet interval reached |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | BUS_W | Transmit word |
| tx_keep | input | BUS_W/8 | Active-high valid-byte mask of the transmit word |
| rx_cyc | input | 1 | Slave is presenting receive data this cycle |
| rx_valid | output | 1 | Receive word valid (one-cycle pulse) |
| rx_data | output | BUS_W | Receive word |
| rx_keep | output | BUS_W/8 | Active-high valid-byte mask of the receive word |
| bus_din | input | BUS_W | Data pins as seen from the pads |
| bus_be_n_in | input | BUS_W/8 | Byte-enable pins as seen from the pads (active low) |
| bus_dout | output | BUS_W | Data pin drive values |
| bus_be_n_out | output | BUS_W/8 | Byte-enable drive values (active low) |
| hi_oe | output | 1 | Drive enable for the upper data half and upper byte enables |
| lo_oe | output | 1 | Drive enable for the lower data half and lower byte enables |

## Verification
The bench builds the block with BUS_W=64 and IDLE_LIMIT=6. The short quiet limit lets the idle counter saturate, raise the timeout and then pull the receive half into drive within a handful of cycles. The same run also covers a receive cycle that clears the timeout and releases the half again. Using the full 64-bit width means each mode exercises every byte lane. Shared mode checks the complete eight-lane mapping in both directions. Split mode shows that the unused halves are zeroed or held inactive.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  typedef enum logic {
    MODE_SHARED = 1'b0,
    MODE_SPLIT  = 1'b1
  } bus_mode_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/sbd_tx_lanes.sv
module sbd_tx_lanes
  import sbd_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  bus_mode_e                 mode,
  input  logic                      fire,
  input  logic [BUS_W-1:0]          wdata,
  input  logic [BUS_W/BYTE_W-1:0]   wkeep,
  output logic [BUS_W-1:0]          pad_data,
  output logic [BUS_W/BYTE_W-1:0]   pad_be_n
);

  localparam int LANES  = BUS_W / BYTE_W;
  localparam int HALF_L = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] d_q;
    logic              be_q;

    if (i >= HALF_L) begin : g_upper
      // upper lanes: full word lane in shared mode, low word lane in split mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q  <= '0;
          be_q <= 1'b1;
        end else if (fire) begin
          if (mode == MODE_SPLIT) begin
            d_q  <= wdata[BYTE_W*(i-HALF_L) +: BYTE_W];
            be_q <= ~wkeep[i-HALF_L];
          end else begin
            d_q  <= wdata[BYTE_W*i +: BYTE_W];
            be_q <= ~wkeep[i];
          end
        end else begin
          be_q <= 1'b1;
        end
      end
    end else begin : g_lower
      // lower lanes carry transmit bytes only in shared mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q  <= '0;
          be_q <= 1'b1;
        end else if (mode == MODE_SPLIT) begin
          d_q  <= '0;
          be_q <= 1'b1;
        end else if (fire) begin
          d_q  <= wdata[BYTE_W*i +: BYTE_W];
          be_q <= ~wkeep[i];
        end else begin
          be_q <= 1'b1;
        end
      end
    end

    assign pad_data[BYTE_W*i +: BYTE_W] = d_q;
    assign pad_be_n[i]                  = be_q;
  end

endmodule

// File: rtl/sbd_rx_lanes.sv
module sbd_rx_lanes
  import sbd_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  bus_mode_e                 mode,
  input  logic                      cap,
  input  logic [BUS_W-1:0]          pad_data,
  input  logic [BUS_W/BYTE_W-1:0]   pad_be_n,
  output logic                      rvalid,
  output logic [BUS_W-1:0]          rdata,
  output logic [BUS_W/BYTE_W-1:0]   rkeep
);

  localparam int LANES  = BUS_W / BYTE_W;
  localparam int HALF_L = LANES / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= cap;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] d_q;
    logic              k_q;

    if (i < HALF_L) begin : g_lower
      // lower lanes receive in both modes
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= '0;
          k_q <= 1'b0;
        end else if (cap) begin
          d_q <= pad_data[BYTE_W*i +: BYTE_W];
          k_q <= ~pad_be_n[i];
        end
      end
    end else begin : g_upper
      // upper lanes belong to the transmit half in split mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= '0;
          k_q <= 1'b0;
        end else if (cap) begin
          if (mode == MODE_SPLIT) begin
            d_q <= '0;
            k_q <= 1'b0;
          end else begin
            d_q <= pad_data[BYTE_W*i +: BYTE_W];
            k_q <= ~pad_be_n[i];
          end
        end
      end
    end

    assign rdata[BYTE_W*i +: BYTE_W] = d_q;
    assign rkeep[i]                  = k_q;
  end

endmodule

// File: rtl/sbd_idle_timer.sv
module sbd_idle_timer
  import sbd_pkg::*;
#(
  parameter int IDLE_LIMIT = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e mode,
  input  logic      rx_cyc,
  output logic      timeout
);

  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(IDLE_LIMIT);

  logic [CNT_W-1:0] quiet_q;

  // saturating count of edges without a receive cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (mode != MODE_SPLIT || rx_cyc) begin
      quiet_q <= '0;
    end else if (quiet_q != LIMIT_V) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign timeout = (mode == MODE_SPLIT) && (quiet_q == LIMIT_V);

endmodule

// File: rtl/split_bus_datapath.sv
module split_bus_datapath
  import sbd_pkg::*;
#(
  parameter int BUS_W      = 64,
  parameter int IDLE_LIMIT = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_split,
  input  logic                    cfg_many_slaves,
  output logic                    slave_sel,
  input  logic                    dev_reset_req,
  output logic                    idle_timeout,
  input  logic                    tx_valid,
  output logic                    tx_ready,
  input  logic [BUS_W-1:0]        tx_data,
  input  logic [BUS_W/8-1:0]      tx_keep,
  input  logic                    rx_cyc,
  output logic                    rx_valid,
  output logic [BUS_W-1:0]        rx_data,
  output logic [BUS_W/8-1:0]      rx_keep,
  input  logic [BUS_W-1:0]        bus_din,
  input  logic [BUS_W/8-1:0]      bus_be_n_in,
  output logic [BUS_W-1:0]        bus_dout,
  output logic [BUS_W/8-1:0]      bus_be_n_out,
  output logic                    hi_oe,
  output logic                    lo_oe
);

  bus_mode_e mode_q;
  logic      slave_q;
  logic      fire;
  logic      hi_oe_q;
  logic      lo_oe_q;
  logic      quiet_hit;

  // static configuration, sampled every edge (also during reset)
  always_ff @(posedge clk) begin
    mode_q  <= bus_mode_e'(cfg_split);
    slave_q <= cfg_many_slaves;
  end

  assign tx_ready = rst_n && ((mode_q == MODE_SPLIT) || !rx_cyc);
  assign fire     = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_oe_q <= 1'b0;
      lo_oe_q <= 1'b0;
    end else if (mode_q == MODE_SPLIT) begin
      hi_oe_q <= 1'b1;
      lo_oe_q <= !rx_cyc && (dev_reset_req || quiet_hit);
    end else begin
      hi_oe_q <= fire;
      lo_oe_q <= fire;
    end
  end

  sbd_tx_lanes #(.BUS_W(BUS_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .fire     (fire),
    .wdata    (tx_data),
    .wkeep    (tx_keep),
    .pad_data (bus_dout),
    .pad_be_n (bus_be_n_out)
  );

  sbd_rx_lanes #(.BUS_W(BUS_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .cap      (rx_cyc),
    .pad_data (bus_din),
    .pad_be_n (bus_be_n_in),
    .rvalid   (rx_valid),
    .rdata    (rx_data),
    .rkeep    (rx_keep)
  );

  sbd_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .rx_cyc  (rx_cyc),
    .timeout (quiet_hit)
  );

  assign idle_timeout = quiet_hit;
  assign slave_sel    = slave_q;
  assign hi_oe        = hi_oe_q;
  assign lo_oe        = lo_oe_q;

endmodule

// File: rtl/sbd_chk.sv
module sbd_chk #(
  parameter int BUS_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_split,
  input logic               cfg_many_slaves,
  input logic               slave_sel,
  input logic               dev_reset_req,
  input logic               idle_timeout,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [BUS_W-1:0]   tx_data,
  input logic [BUS_W/8-1:0] tx_keep,
  input logic               rx_cyc,
  input logic               rx_valid,
  input logic [BUS_W-1:0]   bus_dout,
  input logic [BUS_W/8-1:0] bus_be_n_out,
  input logic               hi_oe,
  input logic               lo_oe
);

  // R2
  shared_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_split && tx_valid && tx_ready) |=>
      (hi_oe && lo_oe && bus_dout == $past(tx_data) && bus_be_n_out == ~$past(tx_keep)));

  // R3
  shared_rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_split && rx_cyc) |-> !tx_ready);

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cyc |=> rx_valid);

  // R4
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_cyc |=> !rx_valid);

  // R6
  split_hi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_split |=> hi_oe);

  // R8
  split_lo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_split && rx_cyc) |=> !lo_oe);

  // R8
  split_lo_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_split && dev_reset_req && !rx_cyc) |=> lo_oe);

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_split && rx_cyc) |=> !idle_timeout);

  // R10
  shared_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |=> !idle_timeout);

  // R11
  slave_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (slave_sel == $past(cfg_many_slaves)));

endmodule

bind split_bus_datapath sbd_chk #(.BUS_W(BUS_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_split       (cfg_split),
  .cfg_many_slaves (cfg_many_slaves),
  .slave_sel       (slave_sel),
  .dev_reset_req   (dev_reset_req),
  .idle_timeout    (idle_timeout),
  .tx_valid        (tx_valid),
  .tx_ready        (tx_ready),
  .tx_data         (tx_data),
  .tx_keep         (tx_keep),
  .rx_cyc          (rx_cyc),
  .rx_valid        (rx_valid),
  .bus_dout        (bus_dout),
  .bus_be_n_out    (bus_be_n_out),
  .hi_oe           (hi_oe),
  .lo_oe           (lo_oe)
);

// File: tb/split_bus_datapath_tb.sv
`timescale 1ns/1ps
module split_bus_datapath_tb;

  localparam int BUS_W = 64;
  localparam int LIM   = 6;
  localparam int NV    = 12;

  typedef struct packed {
    logic        split;
    logic        txv;
    logic [63:0] txd;
    logic [7:0]  txk;
    logic        rxc;
    logic [63:0] din;
    logic [7:0]  bein;
    logic        rreq;
    logic        e_rdy;
    logic        e_hi;
    logic        e_lo;
    logic [63:0] e_dout;
    logic [7:0]  e_ben;
    logic        e_rxv;
    logic [63:0] e_rxd;
    logic [7:0]  e_rxk;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // shared mode
    '{1'b0, 1'b1, 64'h1122334455667788, 8'hFF, 1'b0, 64'h0, 8'hFF, 1'b0,
      1'b1, 1'b1, 1'b1, 64'h1122334455667788, 8'h00, 1'b0, 64'h0, 8'h00},
    '{1'b0, 1'b1, 64'hCAFEF00D12345678, 8'h0F, 1'b0, 64'h0, 8'hFF, 1'b0,
      1'b1, 1'b1, 1'b1, 64'hCAFEF00D12345678, 8'hF0, 1'b0, 64'h0, 8'h00},
    '{1'b0, 1'b1, 64'hDEADBEEFDEADBEEF, 8'hFF, 1'b1, 64'h0102030405060708, 8'h5A, 1'b0,
      1'b0, 1'b0, 1'b0, 64'h0, 8'hFF, 1'b1, 64'h0102030405060708, 8'hA5},
    '{1'b0, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0, 8'hFF, 1'b1,
      1'b1, 1'b0, 1'b0, 64'h0, 8'hFF, 1'b0, 64'h0, 8'h00},
    '{1'b0, 1'b0, 64'h0, 8'h00, 1'b1, 64'hFFEEDDCCBBAA9988, 8'h00, 1'b0,
      1'b0, 1'b0, 1'b0, 64'h0, 8'hFF, 1'b1, 64'hFFEEDDCCBBAA9988, 8'hFF},
    '{1'b0, 1'b1, 64'h0F0E0D0C0B0A0908, 8'h81, 1'b0, 64'h0, 8'hFF, 1'b0,
      1'b1, 1'b1, 1'b1, 64'h0F0E0D0C0B0A0908, 8'h7E, 1'b0, 64'h0, 8'h00},
    // split mode
    '{1'b1, 1'b1, 64'hAAAAAAAA89ABCDEF, 8'hF3, 1'b0, 64'h0, 8'hFF, 1'b0,
      1'b1, 1'b1, 1'b0, 64'h89ABCDEF00000000, 8'hCF, 1'b0, 64'h0, 8'h00},
    '{1'b1, 1'b0, 64'h0, 8'h00, 1'b1, 64'h55555555C0FFEE01, 8'h36, 1'b0,
      1'b1, 1'b1, 1'b0, 64'h89ABCDEF00000000, 8'hFF, 1'b1, 64'h00000000C0FFEE01, 8'h09},
    '{1'b1, 1'b1, 64'h123456789ABCDEF0, 8'h1C, 1'b1, 64'hFFFFFFFF00C0FFEE, 8'hF0, 1'b0,
      1'b1, 1'b1, 1'b0, 64'h9ABCDEF000000000, 8'h3F, 1'b1, 64'h0000000000C0FFEE, 8'h0F},
    '{1'b1, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0, 8'hFF, 1'b1,
      1'b1, 1'b1, 1'b1, 64'h9ABCDEF000000000, 8'hFF, 1'b0, 64'h0, 8'h00},
    '{1'b1, 1'b0, 64'h0, 8'h00, 1'b1, 64'h0, 8'hFF, 1'b1,
      1'b1, 1'b1, 1'b0, 64'h9ABCDEF000000000, 8'hFF, 1'b1, 64'h0, 8'h00},
    '{1'b1, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0, 8'hFF, 1'b0,
      1'b1, 1'b1, 1'b0, 64'h9ABCDEF000000000, 8'hFF, 1'b0, 64'h0, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_split = 1'b0;
  logic              cfg_many_slaves = 1'b0;
  logic              slave_sel;
  logic              dev_reset_req = 1'b0;
  logic              idle_timeout;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [BUS_W-1:0]  tx_data = '0;
  logic [7:0]        tx_keep = '0;
  logic              rx_cyc = 1'b0;
  logic              rx_valid;
  logic [BUS_W-1:0]  rx_data;
  logic [7:0]        rx_keep;
  logic [BUS_W-1:0]  bus_din = '0;
  logic [7:0]        bus_be_n_in = 8'hFF;
  logic [BUS_W-1:0]  bus_dout;
  logic [7:0]        bus_be_n_out;
  logic              hi_oe;
  logic              lo_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  split_bus_datapath #(.BUS_W(BUS_W), .IDLE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_many_slaves(cfg_many_slaves),
    .slave_sel(slave_sel), .dev_reset_req(dev_reset_req), .idle_timeout(idle_timeout),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_keep(tx_keep),
    .rx_cyc(rx_cyc), .rx_valid(rx_valid), .rx_data(rx_data), .rx_keep(rx_keep),
    .bus_din(bus_din), .bus_be_n_in(bus_be_n_in), .bus_dout(bus_dout),
    .bus_be_n_out(bus_be_n_out), .hi_oe(hi_oe), .lo_oe(lo_oe)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_valid = 1'b0; tx_data = '0; tx_keep = '0;
    rx_cyc = 1'b0; bus_din = '0; bus_be_n_in = 8'hFF; dev_reset_req = 1'b0;
  endtask

  task automatic do_reset(input logic split);
    @(negedge clk);
    idle_inputs();
    cfg_split = split;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic prev_split;

    // R1: reset state
    idle_inputs();
    tx_valid = 1'b1;
    cfg_split = 1'b1;
    dev_reset_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "hi_oe", 64'(hi_oe), 64'h0);
    chk("R1", "lo_oe", 64'(lo_oe), 64'h0);
    chk("R1", "rx_valid", 64'(rx_valid), 64'h0);
    chk("R1", "tx_ready", 64'(tx_ready), 64'h0);
    chk("R1", "idle_timeout", 64'(idle_timeout), 64'h0);
    chk("R1", "be_n_out", 64'(bus_be_n_out), 64'hFF);

    // vector table
    prev_split = 1'b0;
    for (int v = 0; v < NV; v++) begin
      string rq_t;
      string rq_r;
      string rq_l;
      if (v == 0 || VECS[v].split != prev_split) do_reset(VECS[v].split);
      prev_split = VECS[v].split;
      rq_t = VECS[v].split ? "R5" : "R2";
      rq_r = VECS[v].split ? "R7" : "R4";
      rq_l = VECS[v].split ? "R8" : "R2";
      @(negedge clk);
      tx_valid = VECS[v].txv; tx_data = VECS[v].txd; tx_keep = VECS[v].txk;
      rx_cyc = VECS[v].rxc; bus_din = VECS[v].din; bus_be_n_in = VECS[v].bein;
      dev_reset_req = VECS[v].rreq;
      #1;
      chk(VECS[v].split ? "R5" : "R3", "tx_ready", 64'(tx_ready), 64'(VECS[v].e_rdy));
      @(posedge clk);
      #1;
      chk(VECS[v].split ? "R6" : "R2", "hi_oe", 64'(hi_oe), 64'(VECS[v].e_hi));
      chk(VECS[v].split ? "R8" : "R10", "lo_oe", 64'(lo_oe), 64'(VECS[v].e_lo));
      chk(rq_t, "be_n_out", 64'(bus_be_n_out), 64'(VECS[v].e_ben));
      if (VECS[v].e_hi || VECS[v].split)
        chk(rq_t, "dout_hi", 64'(bus_dout[63:32]), 64'(VECS[v].e_dout[63:32]));
      if (VECS[v].e_lo || VECS[v].split)
        chk(rq_l, "dout_lo", 64'(bus_dout[31:0]), 64'(VECS[v].e_dout[31:0]));
      chk(rq_r, "rx_valid", 64'(rx_valid), 64'(VECS[v].e_rxv));
      if (VECS[v].e_rxv) begin
        chk(rq_r, "rx_data", rx_data, VECS[v].e_rxd);
        chk(rq_r, "rx_keep", 64'(rx_keep), 64'(VECS[v].e_rxk));
      end
      if (!VECS[v].split)
        chk("R10", "idle_timeout", 64'(idle_timeout), 64'h0);
    end

    // R9: idle timeout in split mode
    do_reset(1'b1);
    repeat (LIM - 1) @(posedge clk);
    #1;
    chk("R9", "idle_timeout before limit", 64'(idle_timeout), 64'h0);
    chk("R8", "lo_oe before limit", 64'(lo_oe), 64'h0);
    @(posedge clk);
    #1;
    chk("R9", "idle_timeout at limit", 64'(idle_timeout), 64'h1);
    chk("R8", "lo_oe at limit", 64'(lo_oe), 64'h0);
    @(posedge clk);
    #1;
    chk("R8", "lo_oe after timeout", 64'(lo_oe), 64'h1);
    chk("R8", "lo be_n", 64'(bus_be_n_out[3:0]), 64'hF);
    chk("R8", "lo dout", 64'(bus_dout[31:0]), 64'h0);
    @(negedge clk);
    rx_cyc = 1'b1;
    @(posedge clk);
    #1;
    chk("R9", "idle_timeout cleared", 64'(idle_timeout), 64'h0);
    chk("R8", "lo_oe released", 64'(lo_oe), 64'h0);
    @(negedge clk);
    rx_cyc = 1'b0;

    // R10: shared mode never times out, reset request ignored
    do_reset(1'b0);
    @(negedge clk);
    dev_reset_req = 1'b1;
    repeat (LIM + 3) @(posedge clk);
    #1;
    chk("R10", "idle_timeout shared", 64'(idle_timeout), 64'h0);
    chk("R10", "lo_oe shared", 64'(lo_oe), 64'h0);
    chk("R10", "hi_oe shared", 64'(hi_oe), 64'h0);
    chk("R10", "be_n_out shared", 64'(bus_be_n_out), 64'hFF);
    @(negedge clk);
    dev_reset_req = 1'b0;

    // R11: sub-mode flag
    @(negedge clk);
    cfg_many_slaves = 1'b1;
    @(posedge clk);
    #1;
    chk("R11", "slave_sel set", 64'(slave_sel), 64'h1);
    @(negedge clk);
    cfg_many_slaves = 1'b0;
    @(posedge clk);
    #1;
    chk("R11", "slave_sel clear", 64'(slave_sel), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule